// File: doc/BRIEF.md
# Software-Refilled Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses for a processor that uses 4 KB pages. It holds a small set of translations with no fixed relation between an entry's slot and the address it covers. Every lookup compares the virtual page number and the current address-space identifier against all slots in parallel. The page offset (the low 12 bits) passes straight through, and the physical frame number of the matching slot replaces the upper 20 bits.

When no slot matches, the block walks no page table. It raises a refill exception for that lookup and records the full failing virtual address in a readable register. Software then writes the missing translation into a chosen slot through a dedicated write port and repeats the access, which now hits. A slot marked global matches any address-space identifier. An invalidate-all input empties the buffer at run time.

A lookup request is registered on one clock edge. The match runs combinationally from that registered request, and the result appears after the following edge.

Top module: `soft_tlb`

## Requirements
- R1: A synchronous reset invalidates every slot and clears `respValid`, `hit`, `refillExc`, `multiHit`, `physAddr` and `badVaddr` to zero. Any lookup after reset misses.
- R2: A request presented with `lookupValid` high is captured at one rising edge, and its result is on the outputs after the next rising edge, with `respValid` high for exactly that one cycle.
- R3: A slot matches when it is valid, its stored page number equals `lookupVa[31:12]`, and either its global bit is 1 or its stored identifier equals `curAsid`. On a match `hit`=1, `refillExc`=0 and `physAddr`={frame number, `lookupVa[11:0]`}.
- R4: A non-global slot whose identifier differs from `curAsid` does not match, even when the page numbers are equal. A global slot matches whatever the value of `curAsid`.
- R5: A lookup that matches no slot gives `refillExc`=1, `hit`=0 and `physAddr`=0.
- R6: `badVaddr` takes the full 32-bit virtual address of a missing lookup in the same cycle that `refillExc` is shown. It keeps its value across later hits and idle cycles.
- R7: With `wrEn` high, slot `wrIdx` is loaded with `wrGlobal`, `wrAsid`, `wrVpn` and `wrPfn` and marked valid at that edge. Any lookup captured at that edge or later sees the new contents, and a second write to the same slot replaces them.
- R8: When several slots match, the frame number of the lowest-indexed matching slot is used and `multiHit`=1. With a single match, `multiHit`=0.
- R9: `invalidateAll` marks every slot invalid at the next edge and takes precedence over a write in the same cycle.
- R10: In a cycle whose result has no request behind it, `respValid`, `hit`, `refillExc` and `multiHit` are 0.
- R11: After a miss, software writes the missing translation and repeats the same address, and that repeated lookup hits with the new frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 32 | Virtual address to translate |
| curAsid | input | 8 | Current address-space identifier |
| wrEn | input | 1 | Slot write strobe |
| wrIdx | input | 4 | Slot to write |
| wrGlobal | input | 1 | Global flag for the written slot |
| wrAsid | input | 8 | Identifier for the written slot |
| wrVpn | input | 20 | Virtual page number for the written slot |
| wrPfn | input | 20 | Physical frame number for the written slot |
| invalidateAll | input | 1 | Invalidate every slot |
| respValid | output | 1 | Result of a lookup is present |
| hit | output | 1 | Lookup matched a slot |
| physAddr | output | 32 | Translated address (zero on a miss) |
| refillExc | output | 1 | Refill exception: lookup matched nothing |
| badVaddr | output | 32 | Last virtual address that missed |
| multiHit | output | 1 | More than one slot matched (debug) |

## Verification
The bench goes after identifier handling. Two slots share one page number under different identifiers, so a design that ignored the identifier would return the wrong frame number. A design that ignored the global bit would miss on the global slots. Invalid slots left with page number zero are probed, so a design that skipped the valid bit would hit on them. Overlapping global and private entries show whether the lowest index wins and whether the multiple-match flag rises. The bench also checks that `badVaddr` holds through hits, so a register that loaded on every lookup would fail. It writes and invalidates in the same cycle, so a design that let the write win would still hit afterwards.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int unsigned DEF_VA_W    = 32;
  localparam int unsigned DEF_PA_W    = 32;
  localparam int unsigned DEF_PAGE_W  = 12;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_ENTRIES = 16;

  // strobes from control to datapath, all valid in the current cycle
  typedef struct packed {
    logic lookup;  // registered request is present
    logic write;   // load one slot at the coming edge
    logic flush;   // clear all valid bits at the coming edge
  } tlb_strobe_t;
endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int unsigned VA_W   = DEF_VA_W,
  parameter int unsigned ASID_W = DEF_ASID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              wrEn,
  input  logic              invalidateAll,
  output tlb_strobe_t       stb,
  output logic [VA_W-1:0]   reqVa,
  output logic [ASID_W-1:0] reqAsid
);
  logic reqValid;

  // request stage: the lookup is compared from these registers
  always_ff @(posedge clk) begin
    if (rst) begin
      reqValid <= 1'b0;
      reqVa    <= '0;
      reqAsid  <= '0;
    end else begin
      reqValid <= lookupValid;
      if (lookupValid) begin
        reqVa   <= lookupVa;
        reqAsid <= curAsid;
      end
    end
  end

  always_comb begin
    stb.lookup = reqValid;
    stb.write  = wrEn;
    stb.flush  = invalidateAll;
  end

  // R2: a request captured this edge drives a compare in the next cycle
  p_req_capture_r2: assert property (@(posedge clk) disable iff (rst)
    lookupValid |=> stb.lookup);
  p_req_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !lookupValid |=> !stb.lookup);
endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int unsigned VA_W    = DEF_VA_W,
  parameter int unsigned PA_W    = DEF_PA_W,
  parameter int unsigned PAGE_W  = DEF_PAGE_W,
  parameter int unsigned ASID_W  = DEF_ASID_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned VPN_W  = VA_W - PAGE_W,
  localparam int unsigned PFN_W  = PA_W - PAGE_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  tlb_strobe_t       stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrGlobal,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  output logic              respValid,
  output logic              hit,
  output logic [PA_W-1:0]   physAddr,
  output logic              refillExc,
  output logic [VA_W-1:0]   badVaddr,
  output logic              multiHit
);
  logic [ENTRIES-1:0] entValid;
  logic               entGlobal [ENTRIES];
  logic [ASID_W-1:0]  entAsid   [ENTRIES];
  logic [VPN_W-1:0]   entVpn    [ENTRIES];
  logic [PFN_W-1:0]   entPfn    [ENTRIES];

  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  logic               anyMatch;
  logic               manyMatch;
  logic [VPN_W-1:0]   reqVpn;

  assign reqVpn = reqVa[VA_W-1:PAGE_W];

  // valid bits: flush wins over a write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            entValid <= '0;
    else if (stb.flush) entValid <= '0;
    else if (stb.write) entValid[wrIdx] <= 1'b1;
  end

  // slot contents carry no reset; validity alone gates matching
  always_ff @(posedge clk) begin
    if (stb.write) begin
      entGlobal[wrIdx] <= wrGlobal;
      entAsid[wrIdx]   <= wrAsid;
      entVpn[wrIdx]    <= wrVpn;
      entPfn[wrIdx]    <= wrPfn;
    end
  end

  // one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entVpn[g] == reqVpn) &&
                         (entGlobal[g] || (entAsid[g] == reqAsid));
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (matchVec[i]) selIdx = IDX_W'(i);
    anyMatch  = |matchVec;
    manyMatch = (matchVec & (matchVec - 1'b1)) != '0;
  end

  // result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      respValid <= 1'b0;
      hit       <= 1'b0;
      refillExc <= 1'b0;
      multiHit  <= 1'b0;
      physAddr  <= '0;
      badVaddr  <= '0;
    end else begin
      respValid <= stb.lookup;
      hit       <= stb.lookup && anyMatch;
      refillExc <= stb.lookup && !anyMatch;
      multiHit  <= stb.lookup && manyMatch;
      physAddr  <= (stb.lookup && anyMatch) ?
                   {entPfn[selIdx], reqVa[PAGE_W-1:0]} : '0;
      if (stb.lookup && !anyMatch) badVaddr <= reqVa;
    end
  end

  // R9: invalidate-all empties every slot one edge later
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    stb.flush |=> (entValid == '0));
  // R7: a write alone leaves its slot valid
  p_write_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.write && !stb.flush) |=> entValid[$past(wrIdx)]);
  // R2: one result per request, one cycle later
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    stb.lookup |=> respValid);
  // R10: no result without a request
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !respValid |-> !(hit || refillExc || multiHit));
  // R8: multiple-match flag only with a hit
  p_multi_hit_r8: assert property (@(posedge clk) disable iff (rst)
    multiHit |-> hit);
  // R6: faulting address register moves only with an exception
  p_badva_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(badVaddr) |-> refillExc);
  // R5: a miss carries no translation
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
    refillExc |-> (physAddr == '0 && !hit));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int unsigned VA_W    = DEF_VA_W,
  parameter int unsigned PA_W    = DEF_PA_W,
  parameter int unsigned PAGE_W  = DEF_PAGE_W,
  parameter int unsigned ASID_W  = DEF_ASID_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned VPN_W  = VA_W - PAGE_W,
  localparam int unsigned PFN_W  = PA_W - PAGE_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrGlobal,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic              invalidateAll,
  output logic              respValid,
  output logic              hit,
  output logic [PA_W-1:0]   physAddr,
  output logic              refillExc,
  output logic [VA_W-1:0]   badVaddr,
  output logic              multiHit
);
  tlb_strobe_t       stb;
  logic [VA_W-1:0]   reqVa;
  logic [ASID_W-1:0] reqAsid;

  soft_tlb_ctrl #(.VA_W(VA_W), .ASID_W(ASID_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .curAsid(curAsid),
    .wrEn(wrEn), .invalidateAll(invalidateAll),
    .stb(stb), .reqVa(reqVa), .reqAsid(reqAsid)
  );

  soft_tlb_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W),
    .ASID_W(ASID_W), .ENTRIES(ENTRIES)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .wrIdx(wrIdx), .wrGlobal(wrGlobal), .wrAsid(wrAsid),
    .wrVpn(wrVpn), .wrPfn(wrPfn),
    .reqVa(reqVa), .reqAsid(reqAsid),
    .respValid(respValid), .hit(hit), .physAddr(physAddr),
    .refillExc(refillExc), .badVaddr(badVaddr), .multiHit(multiHit)
  );

  // R3: page offset of a hit is the offset of the captured request
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> (physAddr[PAGE_W-1:0] == $past(reqVa[PAGE_W-1:0])));
endmodule

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [7:0]  curAsid = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic        wrGlobal = 1'b0;
  logic [7:0]  wrAsid = '0;
  logic [19:0] wrVpn = '0;
  logic [19:0] wrPfn = '0;
  logic        invalidateAll = 1'b0;
  logic        respValid, hit, refillExc, multiHit;
  logic [31:0] physAddr, badVaddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] lastMiss = '0;

  always #5 clk = ~clk;

  soft_tlb dut (
    .clk(clk), .rst(rst), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .curAsid(curAsid), .wrEn(wrEn), .wrIdx(wrIdx), .wrGlobal(wrGlobal),
    .wrAsid(wrAsid), .wrVpn(wrVpn), .wrPfn(wrPfn),
    .invalidateAll(invalidateAll), .respValid(respValid), .hit(hit),
    .physAddr(physAddr), .refillExc(refillExc), .badVaddr(badVaddr),
    .multiHit(multiHit)
  );

  // lookup table: address, identifier, expected hit, address, multi flag
  localparam int NV = 9;
  localparam logic [31:0] V_VA   [NV] = '{32'h1234_5678, 32'h1234_5ABC,
    32'h1234_5000, 32'h0040_0FFF, 32'h0A0A_0123, 32'h0A0A_0123,
    32'hFFFF_F001, 32'h0040_1000, 32'h0000_0000};
  localparam logic [7:0]  V_ASID [NV] = '{8'd5, 8'd7, 8'd3, 8'd42, 8'd9,
    8'd1, 8'd0, 8'd5, 8'd0};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] V_PA   [NV] = '{32'hABCD_E678, 32'h2222_2ABC,
    32'h0, 32'h1111_1FFF, 32'h3333_3123, 32'h3333_3123, 32'h0000_1001,
    32'h0, 32'h0};
  localparam logic        V_MUL  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0};
  localparam string       V_REQ  [NV] = '{"R3", "R4", "R4", "R4", "R8",
    "R8", "R3", "R5", "R1"};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeSlot(input logic [3:0] idx, input logic g,
                           input logic [7:0] asid, input logic [19:0] vpn,
                           input logic [19:0] pfn, input logic flush);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrGlobal = g; wrAsid = asid;
    wrVpn = vpn; wrPfn = pfn; invalidateAll = flush;
    @(negedge clk);
    wrEn = 1'b0; invalidateAll = 1'b0;
  endtask

  // drives one request and returns at the negedge where its result shows
  task automatic lookup(input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = va; curAsid = asid;
    @(negedge clk);
    lookupValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectHit(input string req, input logic [31:0] pa,
                           input logic multi);
    chk(req, "respValid", {31'b0, respValid}, 32'd1);
    chk(req, "hit", {31'b0, hit}, 32'd1);
    chk(req, "refillExc", {31'b0, refillExc}, 32'd0);
    chk(req, "physAddr", physAddr, pa);
    chk(req, "multiHit", {31'b0, multiHit}, {31'b0, multi});
    chk("R6", "badVaddr held", badVaddr, lastMiss);
  endtask

  task automatic expectMiss(input string req, input logic [31:0] va);
    chk(req, "respValid", {31'b0, respValid}, 32'd1);
    chk(req, "hit", {31'b0, hit}, 32'd0);
    chk(req, "refillExc", {31'b0, refillExc}, 32'd1);
    chk("R5", "physAddr", physAddr, 32'h0);
    lastMiss = va;
    chk("R6", "badVaddr", badVaddr, lastMiss);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "respValid", {31'b0, respValid}, 32'd0);
    chk("R1", "hit", {31'b0, hit}, 32'd0);
    chk("R1", "refillExc", {31'b0, refillExc}, 32'd0);
    chk("R1", "physAddr", physAddr, 32'h0);
    chk("R1", "badVaddr", badVaddr, 32'h0);
    chk("R1", "multiHit", {31'b0, multiHit}, 32'd0);
    lookup(32'h1234_5678, 8'd5);
    expectMiss("R1", 32'h1234_5678);

    // load slots
    writeSlot(4'd0, 1'b0, 8'd5,  20'h12345, 20'hABCDE, 1'b0);
    writeSlot(4'd1, 1'b1, 8'd0,  20'h00400, 20'h11111, 1'b0);
    writeSlot(4'd2, 1'b0, 8'd7,  20'h12345, 20'h22222, 1'b0);
    writeSlot(4'd3, 1'b1, 8'd0,  20'h0A0A0, 20'h33333, 1'b0);
    writeSlot(4'd5, 1'b0, 8'd9,  20'h0A0A0, 20'h44444, 1'b0);
    writeSlot(4'd6, 1'b1, 8'd0,  20'hFFFFF, 20'h00001, 1'b0);

    for (int i = 0; i < NV; i++) begin
      lookup(V_VA[i], V_ASID[i]);
      if (V_HIT[i]) expectHit(V_REQ[i], V_PA[i], V_MUL[i]);
      else          expectMiss(V_REQ[i], V_VA[i]);
    end

    // R2 latency: nothing after one edge, result after the second
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = 32'h0040_0123; curAsid = 8'd1;
    @(negedge clk);
    lookupValid = 1'b0;
    chk("R2", "respValid early", {31'b0, respValid}, 32'd0);
    @(negedge clk);
    chk("R2", "respValid", {31'b0, respValid}, 32'd1);
    chk("R2", "physAddr", physAddr, 32'h1111_1123);
    @(negedge clk);
    chk("R2", "respValid one cycle", {31'b0, respValid}, 32'd0);
    // R10 idle
    chk("R10", "hit idle", {31'b0, hit}, 32'd0);
    chk("R10", "refillExc idle", {31'b0, refillExc}, 32'd0);
    chk("R6", "badVaddr idle", badVaddr, lastMiss);

    // R11 refill flow
    lookup(32'h7000_0ABC, 8'd3);
    expectMiss("R11", 32'h7000_0ABC);
    writeSlot(4'd4, 1'b0, 8'd3, 20'h70000, 20'h55555, 1'b0);
    lookup(32'h7000_0ABC, 8'd3);
    expectHit("R11", 32'h5555_5ABC, 1'b0);

    // R7 overwrite same slot
    writeSlot(4'd4, 1'b0, 8'd3, 20'h70000, 20'h66666, 1'b0);
    lookup(32'h7000_0010, 8'd3);
    expectHit("R7", 32'h6666_6010, 1'b0);

    // R9 invalidate with a simultaneous write: invalidate wins
    writeSlot(4'd7, 1'b1, 8'd0, 20'h88888, 20'h99999, 1'b1);
    lookup(32'h8888_8000, 8'd0);
    expectMiss("R9", 32'h8888_8000);
    lookup(32'h1234_5678, 8'd5);
    expectMiss("R9", 32'h1234_5678);
    writeSlot(4'd0, 1'b0, 8'd5, 20'h12345, 20'hABCDE, 1'b0);
    lookup(32'h1234_5678, 8'd5);
    expectHit("R7", 32'hABCD_E678, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule